// File: doc/BRIEF.md
# Device Security State Tracker

This block holds the security state of a device from power-up until the next reset. It merges hardware violation sources with software requests and walks a seven-state lifecycle: a start-up state, a checking state, and then one of an untrusted branch (non-secure), a trusted branch (trusted, then secure), or one of two failure states. The key subsystem reads which key is usable from this block. When the device enters a failure state, the block sends one-cycle strobes that clear the master key and the key-encryption key, and it raises an interrupt.

Several sources raise a violation. The external tamper pin is active low and passes through a two-flop synchronizer. A vector of one-cycle pulses comes from neighbouring units such as the debug gate, the integrity checker, the fuse reader, scan-entry detection, the glitch detector and counter rollover. Software can also declare a violation, and the block treats that exactly like a hardware one. When the hard-fail enable is set, a failure caused by a violation escalates to hard fail. Hard fail requests zeroization once and holds a reset request until the device is reset.

Top module: `trust_state_tracker`

## Requirements
- R1: During reset and in the first cycle after it, the state output is 0 (start-up), the key code is 0 (no key) and every strobe, the interrupt and the reset request are low. One clock later the state is 1 (checking).
- R2: In state 1, a trust write with no violation present moves the state to 3 (trusted), and the key code becomes 2 (master and key-encryption key usable).
- R3: A secure write in state 3 with no violation moves the state to 4 (secure), and the key code stays 2. A secure write in state 1 has no effect.
- R4: In state 1, an external-boot flag or a violation moves the state to 2 (non-secure), and the key code becomes 1 (test key only). A violation wins over a trust write in the same cycle. State 2 then ignores writes and violations until reset.
- R5: In state 3 or 4, a violation or a software soft-fail request moves the state to 5 (soft fail), and the key code becomes 0. In the first cycle of state 5, the master-key clear, the key-encryption-key clear and the interrupt are each high for exactly one cycle.
- R6: In state 5 with hard-fail enable high, the state moves to 6 (hard fail) one clock later if state 5 was entered because of a violation or if a violation is present. The entry cycle of state 6 pulses both key clears, the interrupt and the zeroize request. The reset request stays high and the key code stays 0 for as long as the state is 6.
- R7: With hard-fail enable low, a state-5 entry caused by a violation stays in state 5. A soft fail requested only by software also stays in state 5 while no violation occurs, even when hard fail is enabled.
- R8: The tamper pin is active low. A low level stays invisible to the state for two clock edges and acts on the third edge after it is applied.
- R9: Each bit of the violation-pulse vector, and the software violation declaration, acts as a violation.
- R10: States 5 and 6 are kept until reset. Trust writes and secure writes have no effect in them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tamper_ni | input | 1 | External tamper pin, low means tamper |
| vio_pulse_i | input | 6 | Violation pulses from neighbouring units |
| sw_trust_wr_i | input | 1 | Software write of the trust bit |
| sw_secure_wr_i | input | 1 | Software write of the secure bit |
| sw_softfail_i | input | 1 | Software soft-fail request |
| sw_vio_i | input | 1 | Software-declared violation |
| ext_boot_i | input | 1 | Boot came from an external source |
| hardfail_en_i | input | 1 | Allows escalation to hard fail |
| state_o | output | 3 | Current security state code |
| key_sel_o | output | 2 | Usable key: 0 none, 1 test, 2 master and key-encryption key |
| mk_clear_o | output | 1 | One-cycle master-key clear strobe |
| kek_clear_o | output | 1 | One-cycle key-encryption-key clear strobe |
| irq_o | output | 1 | One-cycle interrupt on entry to a failure state |
| zeroize_o | output | 1 | One-cycle zeroization request on entry to hard fail |
| reset_req_o | output | 1 | Reset request, held high in hard fail |

## Verification
The assertions assume that the only way to leave states 5 and 6 is the reset input, and that the state code changes only at a clock edge. They also assume that the interrupt and the zeroize request occur only together with a change of state. The bench keeps to these rules: it drives every input on the falling edge, and it starts each scenario with a full reset instead of expecting a failure state to clear itself. Violation pulses and software writes last exactly one cycle. The tamper pin is held low for as long as a tamper scenario runs.

// File: rtl/tss_pkg.sv
package tss_pkg;
    localparam int STATE_W = 3;
    localparam int KEY_W   = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_INIT     = 3'd0,
        ST_CHECK    = 3'd1,
        ST_NONSEC   = 3'd2,
        ST_TRUSTED  = 3'd3,
        ST_SECURE   = 3'd4,
        ST_SOFTFAIL = 3'd5,
        ST_HARDFAIL = 3'd6
    } tss_state_e;

    typedef enum logic [KEY_W-1:0] {
        KEY_NONE   = 2'd0,
        KEY_TEST   = 2'd1,
        KEY_MASTER = 2'd2
    } tss_key_e;

    typedef struct packed {
        tss_state_e state;
        logic       vio_seen;
        logic       irq;
        logic       clr;
        logic       zero;
    } tss_fsm_t;
endpackage

// File: rtl/tss_tamper_sync.sv
module tss_tamper_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tamper_ni,
    output logic tamper_evt_o
);
    logic [STAGES-1:0] sync_d, sync_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                assign sync_d[g] = tamper_ni;
            end else begin : g_next
                assign sync_d[g] = sync_q[g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= sync_d;
    end

    assign tamper_evt_o = ~sync_q[STAGES-1];
endmodule

// File: rtl/tss_vio_merge.sv
module tss_vio_merge #(
    parameter int NUM_SRC = 6
) (
    input  logic [NUM_SRC-1:0] vio_pulse_i,
    input  logic               sw_vio_i,
    input  logic               tamper_evt_i,
    output logic               vio_o
);
    always_comb begin
        vio_o = sw_vio_i | tamper_evt_i;
        for (int i = 0; i < NUM_SRC; i++) begin
            vio_o = vio_o | vio_pulse_i[i];
        end
    end
endmodule

// File: rtl/tss_state_fsm.sv
module tss_state_fsm
    import tss_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       vio_i,
    input  logic       trust_wr_i,
    input  logic       secure_wr_i,
    input  logic       softfail_i,
    input  logic       ext_boot_i,
    input  logic       hardfail_en_i,
    output tss_state_e state_o,
    output logic       irq_o,
    output logic       clr_o,
    output logic       zero_o
);
    tss_fsm_t fsm_d, fsm_q;
    logic     to_fail;

    always_comb begin
        fsm_d      = fsm_q;
        fsm_d.irq  = 1'b0;
        fsm_d.clr  = 1'b0;
        fsm_d.zero = 1'b0;
        case (fsm_q.state)
            ST_INIT: fsm_d.state = ST_CHECK;
            ST_CHECK: begin
                if (vio_i || ext_boot_i) fsm_d.state = ST_NONSEC;
                else if (trust_wr_i)     fsm_d.state = ST_TRUSTED;
            end
            ST_NONSEC: fsm_d.state = ST_NONSEC;
            ST_TRUSTED: begin
                if (vio_i || softfail_i) begin
                    fsm_d.state    = ST_SOFTFAIL;
                    fsm_d.vio_seen = vio_i;
                end else if (secure_wr_i) begin
                    fsm_d.state = ST_SECURE;
                end
            end
            ST_SECURE: begin
                if (vio_i || softfail_i) begin
                    fsm_d.state    = ST_SOFTFAIL;
                    fsm_d.vio_seen = vio_i;
                end
            end
            ST_SOFTFAIL: begin
                if (hardfail_en_i && (fsm_q.vio_seen || vio_i)) fsm_d.state = ST_HARDFAIL;
            end
            ST_HARDFAIL: fsm_d.state = ST_HARDFAIL;
            default:     fsm_d.state = ST_HARDFAIL;
        endcase
        to_fail = (fsm_d.state != fsm_q.state) &&
                  ((fsm_d.state == ST_SOFTFAIL) || (fsm_d.state == ST_HARDFAIL));
        fsm_d.irq  = to_fail;
        fsm_d.clr  = to_fail;
        fsm_d.zero = to_fail && (fsm_d.state == ST_HARDFAIL);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fsm_q.state    <= ST_INIT;
            fsm_q.vio_seen <= 1'b0;
            fsm_q.irq      <= 1'b0;
            fsm_q.clr      <= 1'b0;
            fsm_q.zero     <= 1'b0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign state_o = fsm_q.state;
    assign irq_o   = fsm_q.irq;
    assign clr_o   = fsm_q.clr;
    assign zero_o  = fsm_q.zero;
endmodule

// File: rtl/tss_key_policy.sv
module tss_key_policy
    import tss_pkg::*;
(
    input  tss_state_e state_i,
    output tss_key_e   key_sel_o,
    output logic       reset_req_o
);
    always_comb begin
        unique case (state_i)
            ST_NONSEC:             key_sel_o = KEY_TEST;
            ST_TRUSTED, ST_SECURE: key_sel_o = KEY_MASTER;
            default:               key_sel_o = KEY_NONE;
        endcase
        reset_req_o = (state_i == ST_HARDFAIL);
    end
endmodule

// File: rtl/trust_state_tracker.sv
module trust_state_tracker
    import tss_pkg::*;
#(
    parameter int NUM_VIO_SRC = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   tamper_ni,
    input  logic [NUM_VIO_SRC-1:0] vio_pulse_i,
    input  logic                   sw_trust_wr_i,
    input  logic                   sw_secure_wr_i,
    input  logic                   sw_softfail_i,
    input  logic                   sw_vio_i,
    input  logic                   ext_boot_i,
    input  logic                   hardfail_en_i,
    output logic [STATE_W-1:0]     state_o,
    output logic [KEY_W-1:0]       key_sel_o,
    output logic                   mk_clear_o,
    output logic                   kek_clear_o,
    output logic                   irq_o,
    output logic                   zeroize_o,
    output logic                   reset_req_o
);
    logic       tamper_evt;
    logic       vio;
    logic       clr;
    tss_state_e state;
    tss_key_e   key_sel;

    tss_tamper_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .tamper_ni   (tamper_ni),
        .tamper_evt_o(tamper_evt)
    );

    tss_vio_merge #(.NUM_SRC(NUM_VIO_SRC)) i_merge (
        .vio_pulse_i (vio_pulse_i),
        .sw_vio_i    (sw_vio_i),
        .tamper_evt_i(tamper_evt),
        .vio_o       (vio)
    );

    tss_state_fsm i_fsm (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .vio_i        (vio),
        .trust_wr_i   (sw_trust_wr_i),
        .secure_wr_i  (sw_secure_wr_i),
        .softfail_i   (sw_softfail_i),
        .ext_boot_i   (ext_boot_i),
        .hardfail_en_i(hardfail_en_i),
        .state_o      (state),
        .irq_o        (irq_o),
        .clr_o        (clr),
        .zero_o       (zeroize_o)
    );

    tss_key_policy i_policy (
        .state_i    (state),
        .key_sel_o  (key_sel),
        .reset_req_o(reset_req_o)
    );

    assign state_o     = state;
    assign key_sel_o   = key_sel;
    assign mk_clear_o  = clr;
    assign kek_clear_o = clr;
endmodule

// File: rtl/tss_checker.sv
module tss_checker (
    input logic       clk_i,
    input logic       rst_ni,
    input logic [2:0] state_o,
    input logic [1:0] key_sel_o,
    input logic       mk_clear_o,
    input logic       irq_o,
    input logic       zeroize_o,
    input logic       reset_req_o
);
    a_r1_init_to_check: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_o == 3'd0 |=> state_o == 3'd1);

    a_r3_secure_via_trusted: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 3'd4 && $past(state_o) != 3'd4) |-> $past(state_o) == 3'd3);

    a_r5_irq_on_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> ((state_o == 3'd5 || state_o == 3'd6) && state_o != $past(state_o)));

    a_r5_clear_with_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mk_clear_o |-> irq_o);

    a_r6_reset_req_no_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reset_req_o |-> key_sel_o == 2'd0);

    a_r6_zeroize_on_hard_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
        zeroize_o |-> (state_o == 3'd6 && $past(state_o) == 3'd5));

    a_r10_soft_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_o == 3'd5 |=> (state_o == 3'd5 || state_o == 3'd6));

    a_r10_hard_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_o == 3'd6 |=> state_o == 3'd6);
endmodule

bind trust_state_tracker tss_checker i_tss_checker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .state_o    (state_o),
    .key_sel_o  (key_sel_o),
    .mk_clear_o (mk_clear_o),
    .irq_o      (irq_o),
    .zeroize_o  (zeroize_o),
    .reset_req_o(reset_req_o)
);

// File: tb/test_trust_state_tracker.sv
module test_trust_state_tracker;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tamper_n;
    logic [5:0] vio_pulse;
    logic       trust_wr, secure_wr, softfail, sw_vio, ext_boot, hf_en;
    logic [2:0] state;
    logic [1:0] key_sel;
    logic       mk_clr, kek_clr, irq, zeroize, reset_req;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trust_state_tracker i_trust_state_tracker (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .tamper_ni    (tamper_n),
        .vio_pulse_i  (vio_pulse),
        .sw_trust_wr_i(trust_wr),
        .sw_secure_wr_i(secure_wr),
        .sw_softfail_i(softfail),
        .sw_vio_i     (sw_vio),
        .ext_boot_i   (ext_boot),
        .hardfail_en_i(hf_en),
        .state_o      (state),
        .key_sel_o    (key_sel),
        .mk_clear_o   (mk_clr),
        .kek_clear_o  (kek_clr),
        .irq_o        (irq),
        .zeroize_o    (zeroize),
        .reset_req_o  (reset_req)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_inputs();
        tamper_n  = 1'b1;
        vio_pulse = '0;
        trust_wr  = 1'b0;
        secure_wr = 1'b0;
        softfail  = 1'b0;
        sw_vio    = 1'b0;
        ext_boot  = 1'b0;
        hf_en     = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        clear_inputs();
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    task automatic go_trusted();
        do_reset();
        tick();
        trust_wr = 1'b1;
        tick();
        trust_wr = 1'b0;
    endtask

    task automatic go_secure();
        go_trusted();
        secure_wr = 1'b1;
        tick();
        secure_wr = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 state after reset", state, 0);
        chk("R1 key after reset", key_sel, 0);
        chk("R1 strobes after reset", {mk_clr, kek_clr, irq, zeroize, reset_req}, 0);
        tick();
        chk("R1 state one clock later", state, 1);
    endtask

    task automatic t_trust_secure();
        do_reset();
        tick();
        secure_wr = 1'b1;
        tick();
        secure_wr = 1'b0;
        chk("R3 secure write in checking ignored", state, 1);
        trust_wr = 1'b1;
        tick();
        trust_wr = 1'b0;
        chk("R2 trusted state", state, 3);
        chk("R2 master key", key_sel, 2);
        secure_wr = 1'b1;
        tick();
        secure_wr = 1'b0;
        chk("R3 secure state", state, 4);
        chk("R3 master key in secure", key_sel, 2);
    endtask

    task automatic t_nonsec();
        do_reset();
        tick();
        ext_boot = 1'b1;
        tick();
        ext_boot = 1'b0;
        chk("R4 external boot to non-secure", state, 2);
        chk("R4 test key", key_sel, 1);
        vio_pulse[2] = 1'b1;
        trust_wr = 1'b1;
        tick();
        vio_pulse = '0;
        trust_wr = 1'b0;
        tick();
        chk("R4 non-secure ignores writes and violations", state, 2);
        chk("R4 no interrupt in non-secure", irq, 0);
        do_reset();
        tick();
        vio_pulse[0] = 1'b1;
        trust_wr = 1'b1;
        tick();
        vio_pulse = '0;
        trust_wr = 1'b0;
        chk("R4 violation beats trust write", state, 2);
    endtask

    task automatic t_softfail_sw();
        go_trusted();
        hf_en = 1'b1;
        softfail = 1'b1;
        tick();
        softfail = 1'b0;
        chk("R5 software soft fail", state, 5);
        chk("R5 key none", key_sel, 0);
        chk("R5 entry strobes mk/kek/irq/zero", {mk_clr, kek_clr, irq, zeroize}, 4'b1110);
        tick();
        chk("R7 software soft fail stays", state, 5);
        chk("R5 strobes one cycle only", {mk_clr, kek_clr, irq}, 0);
        trust_wr = 1'b1;
        secure_wr = 1'b1;
        tick();
        trust_wr = 1'b0;
        secure_wr = 1'b0;
        chk("R10 writes ignored in soft fail", state, 5);
        sw_vio = 1'b1;
        tick();
        sw_vio = 1'b0;
        chk("R9 software violation escalates to hard fail", state, 6);
        chk("R6 zeroize on later violation", zeroize, 1);
    endtask

    task automatic t_vio_sources();
        for (int i = 0; i <= 6; i++) begin
            go_secure();
            if (i < 6) vio_pulse[i] = 1'b1;
            else       sw_vio = 1'b1;
            tick();
            vio_pulse = '0;
            sw_vio = 1'b0;
            chk($sformatf("R9 source %0d causes soft fail", i), state, 5);
            tick();
            tick();
            chk($sformatf("R7 source %0d stays soft without enable", i), state, 5);
        end
    endtask

    task automatic t_hardfail();
        go_secure();
        hf_en = 1'b1;
        vio_pulse[3] = 1'b1;
        tick();
        vio_pulse = '0;
        chk("R5 violation soft fail first", state, 5);
        chk("R5 interrupt on soft entry", irq, 1);
        tick();
        chk("R6 escalated state", state, 6);
        chk("R6 entry strobes mk/kek/irq/zero", {mk_clr, kek_clr, irq, zeroize}, 4'b1111);
        chk("R6 reset request", reset_req, 1);
        chk("R6 key none", key_sel, 0);
        trust_wr = 1'b1;
        tick();
        trust_wr = 1'b0;
        tick();
        chk("R10 hard fail kept", state, 6);
        chk("R6 reset request held", reset_req, 1);
        chk("R6 single zeroize pulse", {zeroize, irq}, 0);
        go_trusted();
        vio_pulse[5] = 1'b1;
        tick();
        vio_pulse = '0;
        tick();
        chk("R7 no escalation while disabled", state, 5);
        hf_en = 1'b1;
        tick();
        chk("R6 latched cause escalates on enable", state, 6);
    endtask

    task automatic t_tamper();
        go_trusted();
        tamper_n = 1'b0;
        tick();
        chk("R8 tamper not seen after one edge", state, 3);
        tick();
        chk("R8 tamper not seen after two edges", state, 3);
        tick();
        chk("R8 tamper acts on third edge", state, 5);
        chk("R8 interrupt from tamper", irq, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        clear_inputs();
        rst_n = 1'b0;
        t_reset();
        t_trust_secure();
        t_nonsec();
        t_softfail_sw();
        t_vio_sources();
        t_hardfail();
        t_tamper();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule